// File: doc/BRIEF.md
# Masked Level Interrupt Concentrator with Priority Code Readout

This block gathers sixteen level-sensitive interrupt lines into a status word that tracks the line levels, one bit per line. A software-writable enable mask selects which of those bits count. The block drives a single combined request whenever any enabled status bit is set. There is no latching, no acknowledge and no nesting. A status bit clears as soon as its line drops.

Software reaches the block through a small 16-bit register port with two registers. The first is a read-only source code. It names the lowest-numbered line that is both active and enabled, as that index plus one, shifted left by two. A value of zero therefore means that nothing is pending. The second is the mask, which software can read and write. After reset the mask enables only line 4.

Top module: `vec_irq_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, the status word is zero, the mask reads 0x0010, the source code reads 0 and irq_out is low, whatever the line levels are.
- R2: Each status bit takes the level of its input line at every rising clock edge. Lowering a line clears its bit, with no latching.
- R3: irq_out is high exactly when (status AND mask) is nonzero. It responds one clock after a line change or a mask write.
- R4: A read at byte offset 0x0 returns (i+1)<<2, where i is the index of a pending bit, or 0 when no bit is pending.
- R5: When several bits are pending, i is the lowest-numbered of them.
- R6: Byte offset 0x2 holds the 16-bit mask. A write with reg_wr high at a rising edge stores reg_wdata, and a read returns the stored value.
- R7: Writes to offset 0x0 or to any offset other than 0x2 leave the mask unchanged.
- R8: Reads at any offset other than 0x0 and 0x2, including the odd offsets, return 0.
- R9: Reading the source code changes neither the mask nor irq_out.
- R10: An active line whose mask bit is clear affects neither irq_out nor the source code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_lines | input | 16 | Level-sensitive interrupt inputs |
| reg_addr | input | 4 | Register byte offset |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| irq_out | output | 1 | Combined masked interrupt request |

## Verification
Directed patterns cover the basic cases:
- A single enabled line, which checks the code scaling.
- A single masked-off line, which separates masking from capture.
- Two enabled lines at opposite ends of the word, which separate lowest-index priority from highest-index priority.
- Lines held high during reset, which shows that the reset clears status rather than waiting for the lines.

Random line levels, mixed with random writes to valid and invalid offsets, then compare the code and irq_out with a bench model after every cycle. This catches a wrong shift, an off-by-one index, a decode that accepts the wrong offset, and a mask that updates late.

// File: rtl/vec_irq_pkg.sv
// Package: shared register selector type and code sizing for the interrupt concentrator.
package vec_irq_pkg;

    // Which register a byte offset addresses.
    typedef enum logic [1:0] {
        SEL_CODE = 2'd0,
        SEL_MASK = 2'd1,
        SEL_NONE = 2'd2
    } reg_sel_e;

    // Width needed to hold (N << SHIFT) for N sources.
    function automatic int code_width(input int n_src, input int shift);
        return $clog2(n_src + 1) + shift;
    endfunction

endpackage

// File: rtl/vec_irq_capture.sv
// Level capture: registers each interrupt line into a status bit every cycle.
// Assumes the lines are already synchronous to clk. No latching: a bit tracks its line.
module vec_irq_capture #(
    parameter int N_SRC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] lines,
    output logic [N_SRC-1:0] status
);
    genvar g;
    generate
        for (g = 0; g < N_SRC; g++) begin : g_bit
            // Follow one line level, cleared in reset.
            always_ff @(posedge clk) begin
                if (!rst_n) status[g] <= 1'b0;
                else        status[g] <= lines[g];
            end
        end
    endgenerate
endmodule

// File: rtl/vec_irq_mask.sv
// Enable mask register: loads write data when selected, holds otherwise.
// Assumes wr_sel is already decoded to this register only.
module vec_irq_mask #(
    parameter int              N_SRC    = 16,
    parameter logic [N_SRC-1:0] RST_VAL = 16'h0010
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_sel,
    input  logic [N_SRC-1:0] wdata,
    output logic [N_SRC-1:0] mask
);
    // Store mask on selected write; reset to the default enable set.
    always_ff @(posedge clk) begin
        if (!rst_n)      mask <= RST_VAL;
        else if (wr_sel) mask <= wdata;
    end
endmodule

// File: rtl/vec_irq_prio.sv
// Priority encoder: turns the pending vector into ((lowest set index)+1) << SHIFT, or 0.
// Assumes CODE_W can hold N_SRC << SHIFT.
module vec_irq_prio #(
    parameter int N_SRC  = 16,
    parameter int SHIFT  = 2,
    parameter int CODE_W = vec_irq_pkg::code_width(N_SRC, SHIFT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  pending,
    output logic [CODE_W-1:0] code
);
    // Scan high to low so the lowest pending index is the last one written.
    always_comb begin
        code = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (pending[i]) code = CODE_W'((i + 1) << SHIFT);
        end
    end

    // R4
    code_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code == '0) == (pending == '0));
    // R5
    code_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code != '0) |-> pending[(code >> SHIFT) - 1]);
endmodule

// File: rtl/vec_irq_ctrl.sv
// Top: masked level interrupt concentrator with a two-register 16-bit port.
// Offset 0x0 reads the priority code, offset 0x2 is the mask; other offsets read 0, ignore writes.
// Assumes single-cycle synchronous register writes and combinational reads.
module vec_irq_ctrl #(
    parameter int N_SRC      = 16,
    parameter int DATA_W     = 16,
    parameter int ADDR_W     = 4,
    parameter int CODE_SHIFT = 2,
    parameter logic [N_SRC-1:0] MASK_RST  = 16'h0010,
    parameter logic [ADDR_W-1:0] OFS_CODE = 4'h0,
    parameter logic [ADDR_W-1:0] OFS_MASK = 4'h2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  irq_lines,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_out
);
    import vec_irq_pkg::*;

    localparam int CODE_W = code_width(N_SRC, CODE_SHIFT);

    logic [N_SRC-1:0]  status_q;
    logic [N_SRC-1:0]  mask_q;
    logic [N_SRC-1:0]  pending;
    logic [CODE_W-1:0] code;
    reg_sel_e          sel;
    logic              past_ok;

    // Decode the byte offset into a register selector.
    always_comb begin
        if (reg_addr == OFS_CODE)      sel = SEL_CODE;
        else if (reg_addr == OFS_MASK) sel = SEL_MASK;
        else                           sel = SEL_NONE;
    end

    vec_irq_capture #(.N_SRC(N_SRC)) u_cap (
        .clk(clk), .rst_n(rst_n), .lines(irq_lines), .status(status_q)
    );

    vec_irq_mask #(.N_SRC(N_SRC), .RST_VAL(MASK_RST)) u_mask (
        .clk(clk), .rst_n(rst_n),
        .wr_sel(reg_wr && (sel == SEL_MASK)),
        .wdata(reg_wdata[N_SRC-1:0]),
        .mask(mask_q)
    );

    // Enabled and active sources.
    assign pending = status_q & mask_q;

    vec_irq_prio #(.N_SRC(N_SRC), .SHIFT(CODE_SHIFT), .CODE_W(CODE_W)) u_prio (
        .clk(clk), .rst_n(rst_n), .pending(pending), .code(code)
    );

    // Combined request from registered status and mask.
    assign irq_out = |pending;

    // Select read data by register.
    always_comb begin
        case (sel)
            SEL_CODE: reg_rdata = DATA_W'(code);
            SEL_MASK: reg_rdata = DATA_W'(mask_q);
            default:  reg_rdata = '0;
        endcase
    end

    // Marks cycles with a valid previous cycle out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R1
    rst_mask_chk: assert property (@(posedge clk) !rst_n |=> mask_q == MASK_RST && status_q == '0);
    // R2
    status_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> status_q == $past(irq_lines));
    // R3
    irq_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (code != '0));
    // R6
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_MASK) |=> mask_q == $past(reg_wdata[N_SRC-1:0]));
    // R7
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !(reg_wr && reg_addr == OFS_MASK)) |=> $stable(mask_q));
endmodule

// File: tb/vec_irq_ctrl_tb.sv
`timescale 1ns/100ps
module vec_irq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_lines = '0;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq_out;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] m_stat = '0;
    logic [15:0] m_mask = 16'h0010;

    always #2 clk = ~clk;

    vec_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    function automatic logic [15:0] exp_code(input logic [15:0] s, input logic [15:0] m);
        for (int i = 0; i < 16; i++) if (s[i] & m[i]) return 16'((i + 1) << 2);
        return 16'h0;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock: drive at negedge, update model at posedge.
    task automatic cyc(input logic [15:0] lv, input logic wr, input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        irq_lines = lv; reg_wr = wr; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #0.5;
        reg_wr = 1'b0;
        if (rst_n) begin
            m_stat = lv;
            if (wr && a == 4'h2) m_mask = d;
        end
    endtask

    task automatic rd(input string req, input logic [3:0] a, input logic [15:0] exp);
        reg_addr = a;
        #0.2;
        check(req, reg_rdata, exp);
    endtask

    task automatic chk_state(input string req);
        check(req, {15'h0, irq_out}, {15'h0, exp_code(m_stat, m_mask) != 0});
        rd(req, 4'h0, exp_code(m_stat, m_mask));
    endtask

    initial begin
        #400000;
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        // R1: lines high during reset must not reach status
        cyc(16'hFFFF, 1'b0, 4'h0, 16'h0);
        cyc(16'hFFFF, 1'b0, 4'h0, 16'h0);
        check("R1 irq", {15'h0, irq_out}, 16'h0);
        rd("R1 code", 4'h0, 16'h0);
        rd("R1 mask", 4'h2, 16'h0010);
        @(negedge clk); rst_n = 1'b1; irq_lines = 16'h0;
        m_stat = '0; m_mask = 16'h0010;
        // R2 R3 R4: single enabled line 4 -> (5)<<2
        cyc(16'h0010, 1'b0, 4'h0, 16'h0);
        check("R3 irq", {15'h0, irq_out}, 16'h1);
        rd("R4 code", 4'h0, 16'd20);
        // R2: drop the line, bit clears
        cyc(16'h0000, 1'b0, 4'h0, 16'h0);
        check("R2 clear", {15'h0, irq_out}, 16'h0);
        // R10: masked-off line 0
        cyc(16'h0001, 1'b0, 4'h0, 16'h0);
        check("R10 irq", {15'h0, irq_out}, 16'h0);
        rd("R10 code", 4'h0, 16'h0);
        // R6: mask write, takes effect the next cycle
        cyc(16'h0001, 1'b1, 4'h2, 16'hFFFF);
        rd("R6 mask", 4'h2, 16'hFFFF);
        check("R6 irq", {15'h0, irq_out}, 16'h1);
        rd("R4 code0", 4'h0, 16'd4);
        // R5: lines 2 and 15 -> lowest wins (3<<2)
        cyc(16'h8004, 1'b0, 4'h0, 16'h0);
        rd("R5 code", 4'h0, 16'd12);
        cyc(16'h8000, 1'b0, 4'h0, 16'h0);
        rd("R4 code15", 4'h0, 16'd64);
        // R7: writes to code and unknown offsets ignored
        cyc(16'h8000, 1'b1, 4'h0, 16'h0000);
        rd("R7 ofs0", 4'h2, 16'hFFFF);
        cyc(16'h8000, 1'b1, 4'h6, 16'h0000);
        rd("R7 ofs6", 4'h2, 16'hFFFF);
        cyc(16'h8000, 1'b1, 4'h3, 16'h0000);
        rd("R7 ofs3", 4'h2, 16'hFFFF);
        // R8: unknown reads return 0
        rd("R8 ofs1", 4'h1, 16'h0);
        rd("R8 ofs4", 4'h4, 16'h0);
        rd("R8 ofsE", 4'hE, 16'h0);
        // R9: repeated source reads leave state alone
        cyc(16'h0100, 1'b0, 4'h0, 16'h0);
        rd("R9 read1", 4'h0, 16'd36);
        cyc(16'h0100, 1'b0, 4'h0, 16'h0);
        rd("R9 read2", 4'h0, 16'd36);
        rd("R9 mask", 4'h2, 16'hFFFF);
        check("R9 irq", {15'h0, irq_out}, 16'h1);
        // Random mix of line levels and writes (R2 R3 R4 R5 R6 R7 R10)
        for (int k = 0; k < 400; k++) begin
            logic [15:0] lv;
            logic [3:0]  a;
            logic        w;
            lv = 16'($urandom);
            if ($urandom_range(0, 2) == 0) lv = lv & 16'($urandom);
            a  = ($urandom_range(0, 1) == 0) ? 4'h2 : 4'($urandom);
            w  = ($urandom_range(0, 3) == 0);
            cyc(lv, w, a, 16'($urandom));
            chk_state("R4 random");
            rd("R6 random", 4'h2, m_mask);
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule